// File: doc/BRIEF.md
# Multi-channel piecewise CRC-16 engine

This block keeps a running CRC-16 for up to sixteen frames at once. The frames arrive cut into packets, and packets from different frames may interleave on one byte stream. Each packet carries a channel number. When a packet begins, the block fetches that channel's partial remainder from a small store indexed by channel and places it in the shared byte-parallel CRC register. It then folds in the packet's bytes and writes the partial remainder back when the packet ends. Packets that continue a frame therefore pick up where the previous packet of the same frame stopped, whatever ran on the stream in between.

The byte stream passes through a two-stage delay. The first stage looks up the channel's remainder and the second stage loads it, so the fetch is ready before the first byte of the packet is absorbed. Every byte leaves the block unchanged three cycles after it entered. On the final packet of a transmitted frame, the block adds the two remainder bytes after the data. On the final packet of a received frame, it reports whether the remainder over data plus the received check bytes is zero. In both cases the channel's stored entry is then cleared.

Top module: `pcrc_engine`

## Requirements
- R1: The remainder uses generator x^16 + x^12 + x^5 + 1 (0x1021). Each byte is taken most significant bit first, there is no final inversion, and every frame starts from zero. The bytes "123456789" therefore give 0x31C3.
- R2: Each accepted input byte (in_valid high) appears on out_data with out_valid high and out_crc low exactly 3 cycles after the cycle it was presented.
- R3: A packet whose start byte has in_first high begins from zero, whatever that channel's stored entry holds.
- R4: A packet without in_first continues from the remainder stored for its channel by that channel's previous packet. Packets on other channels in between have no effect on it.
- R5: A packet may start in the cycle right after a packet on the same channel ended. It still continues from that just-finished remainder.
- R6: On the end byte of a packet with in_last high and in_rx low, presented in cycle t, the block emits two extra bytes with out_valid and out_crc high. Bits 15:8 of the remainder come out in cycle t+4 and bits 7:0 in cycle t+5.
- R7: On the end byte of a packet with in_last and in_rx high, presented in cycle t, chk_valid pulses for one cycle in t+3. In that cycle chk_chan holds the channel, and chk_ok is high only if the remainder over all bytes of the frame is zero.
- R8: After a final packet, that channel's entry is zero, so a later packet on that channel without in_first starts from zero.
- R9: A received frame whose packets arrive in a different order than they were sent reports chk_ok low.
- R10: Idle cycles (in_valid low) inside a packet do not change the remainder.
- R11: While in reset and right after it, out_valid, out_crc and chk_valid are low, and every channel's entry is zero.
- R12: After the end byte of a transmit final packet, the source keeps in_valid low for the next two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte present this cycle |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | Byte is the first of a packet |
| in_eop | input | 1 | Byte is the last of a packet |
| in_first | input | 1 | Packet opens a new frame (sampled with in_sop) |
| in_last | input | 1 | Packet closes its frame (sampled with in_eop) |
| in_rx | input | 1 | Packet is checked (1) rather than sent (0), sampled with in_eop |
| in_chan | input | 4 | Channel of the packet |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Delayed data byte or appended remainder byte |
| out_crc | output | 1 | Output byte is an appended remainder byte |
| chk_valid | output | 1 | Frame check result present |
| chk_ok | output | 1 | Remainder of the checked frame was zero |
| chk_chan | output | 4 | Channel of the checked frame |

## Verification
The bench aims at a packet that starts one cycle after a packet on the same channel ends. A store without forwarding would hand back the stale entry there and corrupt every later remainder of that frame. It feeds a frame's packets back both in order and swapped, interleaved with other channels, and checks zero-remainder success in one case and failure in the other. An engine that mixed up channels, skipped the load, or ignored the first-packet flag would get these wrong. It also reuses a channel after its final packet without a first flag, which catches an engine that leaves the entry uncleared. Random packets with idle gaps inside them catch byte loss and timing slips on the delayed stream and on the appended bytes.

// File: rtl/pcrc_pkg.sv
package pcrc_pkg;
  parameter int DATA_W = 8;
  parameter int CHAN_W = 4;
  parameter int CRC_W  = 16;
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021;

  // one byte slot in the delay line
  typedef struct packed {
    logic              vld;
    logic              sop;
    logic              eop;
    logic              first;
    logic              last;
    logic              rx;
    logic [CHAN_W-1:0] chan;
    logic [DATA_W-1:0] data;
  } beat_t;

  // remainder after shifting one byte in, msb first
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] cur,
                                                input logic [DATA_W-1:0] din);
    logic [CRC_W-1:0] r;
    logic             fb;
    r = cur;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb = r[CRC_W-1] ^ din[i];
      r  = {r[CRC_W-2:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction
endpackage

// File: rtl/pcrc_delay.sv
module pcrc_delay
  import pcrc_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  beat_t in_beat,
  output beat_t stg [DEPTH]
);

  beat_t stg_d [DEPTH];

  always_comb begin
    stg_d[0] = in_beat;
    for (int i = 1; i < DEPTH; i++) begin
      stg_d[i] = stg[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) stg[i] <= stg_d[i];
    end
  end

endmodule

// File: rtl/pcrc_store.sv
module pcrc_store #(
  parameter  int ENTRIES = 16,
  parameter  int WORD_W  = 16,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word
);

  logic [WORD_W-1:0] mem_q [ENTRIES];
  logic [WORD_W-1:0] mem_d [ENTRIES];

  // next state: one entry replaced per cycle
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      mem_d[i] = mem_q[i];
    end
    if (wr_en) mem_d[wr_idx] = wr_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < ENTRIES; i++) mem_q[i] <= mem_d[i];
    end
  end

  // read forwards a write landing in this same cycle
  always_comb begin
    if (wr_en && (wr_idx == rd_idx)) rd_word = wr_word;
    else                             rd_word = mem_q[rd_idx];
  end

  // R4: an entry written last cycle reads back unchanged
  a_r4_entry_persists: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && (rd_idx == $past(wr_idx)) && !(wr_en && (wr_idx == rd_idx)))
      |-> (rd_word == $past(wr_word)));

endmodule

// File: rtl/pcrc_core.sv
module pcrc_core
  import pcrc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [CRC_W-1:0]  ld_word,
  input  logic              absorb,
  input  logic              absorb_from_ld,
  input  logic [DATA_W-1:0] byte_in,
  output logic [CRC_W-1:0]  crc_next
);

  logic [CRC_W-1:0] ld_q;
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] base;

  // a packet's first byte starts from the staged value
  always_comb begin
    base     = absorb_from_ld ? ld_q : crc_q;
    crc_next = crc_step(base, byte_in);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ld_q <= '0;
    else if (ld_en) ld_q <= ld_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else if (absorb) crc_q <= crc_next;
  end

endmodule

// File: rtl/pcrc_engine.sv
module pcrc_engine
  import pcrc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic              in_first,
  input  logic              in_last,
  input  logic              in_rx,
  input  logic [CHAN_W-1:0] in_chan,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_crc,
  output logic              chk_valid,
  output logic              chk_ok,
  output logic [CHAN_W-1:0] chk_chan
);

  localparam int DLY     = 2;
  localparam int CHANS   = 1 << CHAN_W;
  localparam int NBYTES  = CRC_W / DATA_W;
  localparam int CNT_W   = $clog2(NBYTES + 1);

  beat_t            in_b;
  beat_t            stg [DLY];
  beat_t            s1, s2;
  logic [CRC_W-1:0] rd_word, ld_word, crc_next, wr_word;
  logic             wr_en, end_tx, end_rx;

  always_comb begin
    in_b.vld   = in_valid;
    in_b.sop   = in_valid & in_sop;
    in_b.eop   = in_valid & in_eop;
    in_b.first = in_first;
    in_b.last  = in_last;
    in_b.rx    = in_rx;
    in_b.chan  = in_chan;
    in_b.data  = in_data;
  end

  pcrc_delay #(.DEPTH(DLY)) u_dly (
    .clk(clk), .rst_n(rst_n), .in_beat(in_b), .stg(stg)
  );

  assign s1 = stg[0];
  assign s2 = stg[DLY-1];

  // stage 1 looks up, stage 2 absorbs from the looked-up value
  assign wr_en   = s2.eop;
  assign end_tx  = s2.eop & s2.last & ~s2.rx;
  assign end_rx  = s2.eop & s2.last &  s2.rx;
  assign wr_word = s2.last ? '0 : crc_next;
  assign ld_word = s1.first ? '0 : rd_word;

  pcrc_store #(.ENTRIES(CHANS), .WORD_W(CRC_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(s2.chan), .wr_word(wr_word),
    .rd_idx(s1.chan), .rd_word(rd_word)
  );

  pcrc_core u_core (
    .clk(clk), .rst_n(rst_n),
    .ld_en(s1.sop), .ld_word(ld_word),
    .absorb(s2.vld), .absorb_from_ld(s2.sop),
    .byte_in(s2.data), .crc_next(crc_next)
  );

  // output stage
  logic [CNT_W-1:0]  app_cnt_q, app_cnt_d;
  logic [CRC_W-1:0]  app_val_q, app_val_d;
  logic              ov_d, oc_d, cv_d, ck_d;
  logic [DATA_W-1:0] od_d;
  logic [CHAN_W-1:0] cc_d;

  always_comb begin
    app_cnt_d = app_cnt_q;
    app_val_d = app_val_q;
    ov_d      = s2.vld;
    od_d      = s2.data;
    oc_d      = 1'b0;
    if (app_cnt_q != '0) begin
      ov_d      = 1'b1;
      oc_d      = 1'b1;
      od_d      = app_val_q[CRC_W-1 -: DATA_W];
      app_val_d = app_val_q << DATA_W;
      app_cnt_d = app_cnt_q - 1'b1;
    end
    if (end_tx) begin
      app_cnt_d = CNT_W'(NBYTES);
      app_val_d = crc_next;
    end
    cv_d = end_rx;
    ck_d = (crc_next == '0);
    cc_d = s2.chan;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      app_cnt_q <= '0;
      app_val_q <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_crc   <= 1'b0;
      chk_valid <= 1'b0;
      chk_ok    <= 1'b0;
      chk_chan  <= '0;
    end else begin
      app_cnt_q <= app_cnt_d;
      app_val_q <= app_val_d;
      out_valid <= ov_d;
      out_data  <= od_d;
      out_crc   <= oc_d;
      chk_valid <= cv_d;
      chk_ok    <= ck_d;
      chk_chan  <= cc_d;
    end
  end

  // R2: a packet start reaches the load stage two cycles later
  a_r2_start_reaches_load: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sop) |=> ##1 (s2.vld && s2.sop));

  // R2: a remainder byte is always a valid byte
  a_r2_crc_implies_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_crc |-> out_valid);

  // R6: appended bytes come as a pair
  a_r6_pair_starts: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_crc) |=> out_crc);

  a_r6_pair_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (out_crc && $past(out_crc)) |=> !out_crc);

  // R12: source leaves room for the appended pair
  a_r12_idle_after_tx_end: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid && in_eop && in_last && !in_rx) || $past(in_valid && in_eop && in_last && !in_rx, 2))
      |-> !in_valid);

endmodule

// File: tb/test_pcrc_engine.sv
module test_pcrc_engine;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_sop, in_eop, in_first, in_last, in_rx;
  logic [7:0] in_data;
  logic [3:0] in_chan;
  logic       out_valid, out_crc, chk_valid, chk_ok;
  logic [7:0] out_data;
  logic [3:0] chk_chan;

  always #2.5 clk = ~clk;

  pcrc_engine i_pcrc_engine (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
    .in_first(in_first), .in_last(in_last), .in_rx(in_rx), .in_chan(in_chan),
    .out_valid(out_valid), .out_data(out_data), .out_crc(out_crc),
    .chk_valid(chk_valid), .chk_ok(chk_ok), .chk_chan(chk_chan)
  );

  int unsigned cyc = 0;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          mon_on = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int unsigned at; logic [7:0] d; logic c; string req; } oexp_t;
  typedef struct { int unsigned at; logic [3:0] ch; logic ok; string req; } cexp_t;
  oexp_t oq[$];
  cexp_t cq[$];
  logic [15:0] mram [16];

  // reference remainder: polynomial division one bit at a time
  function automatic logic [15:0] ref_byte(input logic [15:0] r, input logic [7:0] b);
    logic [15:0] x;
    x = r ^ {b, 8'h00};
    for (int k = 0; k < 8; k++) begin
      x = (x << 1) ^ (x[15] ? 16'h1021 : 16'h0000);
    end
    return x;
  endfunction

  task automatic fail_line(input string req, input string what, input int act, input int exp);
    n_bad++;
    $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    end
  endtask

  task automatic send_pkt(input logic [3:0] ch, input bit first, input bit last, input bit rx,
                          input logic [7:0] bq[$], input int gap_pct, input string req,
                          output logic [15:0] rem);
    logic [15:0] cur;
    int unsigned t_end;
    cur = first ? 16'h0000 : mram[ch];
    for (int i = 0; i < bq.size(); i++) begin
      if (i != 0 && ($urandom % 100) < gap_pct) idle(1 + $urandom % 2); // R10 gaps
      @(negedge clk);
      in_valid = 1'b1; in_data = bq[i]; in_chan = ch;
      in_sop = (i == 0); in_eop = (i == bq.size() - 1);
      in_first = first; in_last = last; in_rx = rx;
      oq.push_back('{cyc + 3, bq[i], 1'b0, req});
      cur = ref_byte(cur, bq[i]);
      t_end = cyc;
    end
    rem = cur;
    if (last) begin
      if (rx) cq.push_back('{t_end + 3, ch, (cur == 16'h0000), req});
      else begin
        oq.push_back('{t_end + 4, cur[15:8], 1'b1, req});
        oq.push_back('{t_end + 5, cur[7:0], 1'b1, req});
      end
      mram[ch] = 16'h0000;
      if (!rx) idle(2); // R12 spacing
    end else begin
      mram[ch] = cur;
    end
  endtask

  // monitor, sampled away from the rising edge
  always @(negedge clk) begin
    if (mon_on) begin
      if (out_valid) begin
        n_cmp++;
        if (oq.size() == 0) fail_line("R2", "unexpected output byte", out_data, 0);
        else begin
          oexp_t e;
          e = oq.pop_front();
          if (e.at != cyc) fail_line(e.req, "output cycle", cyc, e.at);
          else if (out_data !== e.d || out_crc !== e.c)
            fail_line(e.req, "output byte/flag", {out_crc, out_data}, {e.c, e.d});
        end
      end else if (oq.size() != 0 && oq[0].at <= cyc) begin
        oexp_t e;
        e = oq.pop_front();
        n_cmp++;
        fail_line(e.req, "missing output byte", 0, e.d);
      end
      if (chk_valid) begin
        n_cmp++;
        if (cq.size() == 0) fail_line("R7", "unexpected check pulse", chk_chan, 0);
        else begin
          cexp_t e;
          e = cq.pop_front();
          if (e.at != cyc) fail_line(e.req, "check cycle", cyc, e.at);
          else if (chk_ok !== e.ok || chk_chan !== e.ch)
            fail_line(e.req, "check ok/chan", {chk_ok, chk_chan}, {e.ok, e.ch});
        end
      end else if (cq.size() != 0 && cq[0].at <= cyc) begin
        cexp_t e;
        e = cq.pop_front();
        n_cmp++;
        fail_line(e.req, "missing check pulse", 0, e.ok);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0]  q[$];
    logic [7:0]  p1[$], p2[$], p3[$], rx3[$];
    logic [15:0] rem, frame_rem;
    void'($urandom(32'd4711));
    for (int i = 0; i < 16; i++) mram[i] = 16'h0000;
    rst_n = 1'b0; in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    in_first = 1'b0; in_last = 1'b0; in_rx = 1'b0; in_chan = '0; in_data = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R11: outputs quiet in reset
    n_cmp++; if (out_valid !== 1'b0) fail_line("R11", "out_valid in reset", out_valid, 0);
    n_cmp++; if (out_crc !== 1'b0)   fail_line("R11", "out_crc in reset", out_crc, 0);
    n_cmp++; if (chk_valid !== 1'b0) fail_line("R11", "chk_valid in reset", chk_valid, 0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    idle(2);

    // R1: known vector, whole frame in one packet
    q = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    send_pkt(4'd3, 1, 1, 0, q, 0, "R1", rem);
    n_cmp++; if (rem !== 16'h31C3) fail_line("R1", "reference remainder", rem, 16'h31C3);

    // R7: receive the same vector plus its remainder
    q = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39, 8'h31, 8'hC3};
    send_pkt(4'd5, 1, 1, 1, q, 0, "R7", rem);

    // R4: a three-packet frame on channel 1 interleaved with channel 2
    p1 = '{8'hA5, 8'h11, 8'h02};
    p2 = '{8'h7E, 8'hC0, 8'h33, 8'h9D};
    p3 = '{8'h40, 8'h01};
    send_pkt(4'd1, 1, 0, 0, p1, 0, "R4", rem);
    q = '{8'hFF, 8'h00, 8'h5A};
    send_pkt(4'd2, 1, 0, 0, q, 0, "R4", rem);
    send_pkt(4'd1, 0, 0, 0, p2, 0, "R4", rem);
    send_pkt(4'd2, 0, 0, 0, q, 0, "R4", rem);
    send_pkt(4'd1, 0, 1, 0, p3, 0, "R4", frame_rem);

    // R7/R4: loop the frame back in order on channel 6
    rx3 = p3; rx3.push_back(frame_rem[15:8]); rx3.push_back(frame_rem[7:0]);
    send_pkt(4'd6, 1, 0, 1, p1, 0, "R7", rem);
    send_pkt(4'd9, 1, 0, 0, p2, 0, "R4", rem);
    send_pkt(4'd6, 0, 0, 1, p2, 0, "R7", rem);
    send_pkt(4'd6, 0, 1, 1, rx3, 0, "R7", rem);
    n_cmp++; if (rem !== 16'h0000) fail_line("R7", "in-order loopback remainder", rem, 0);

    // R9: swapped packet order must not check clean
    send_pkt(4'd8, 1, 0, 1, p2, 0, "R9", rem);
    send_pkt(4'd8, 0, 0, 1, p1, 0, "R9", rem);
    send_pkt(4'd8, 0, 1, 1, rx3, 0, "R9", rem);
    n_cmp++; if (rem === 16'h0000) fail_line("R9", "reordered remainder nonzero", rem, 1);

    // R5: same channel back to back, single-byte packets, no gap
    q = '{8'h12}; send_pkt(4'd4, 1, 0, 0, q, 0, "R5", rem);
    q = '{8'h34}; send_pkt(4'd4, 0, 0, 0, q, 0, "R5", rem);
    q = '{8'h56, 8'h78}; send_pkt(4'd4, 0, 0, 0, q, 0, "R5", rem);
    q = '{8'h9A}; send_pkt(4'd4, 0, 1, 0, q, 0, "R5", rem);

    // R8: channel 3 was closed; continuing without first starts from zero
    q = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    send_pkt(4'd3, 0, 1, 0, q, 0, "R8", rem);
    n_cmp++; if (rem !== 16'h31C3) fail_line("R8", "cleared entry remainder", rem, 16'h31C3);

    // R3: channel 2 holds an interim value; first flag ignores it
    send_pkt(4'd2, 1, 1, 0, q, 0, "R3", rem);
    n_cmp++; if (rem !== 16'h31C3) fail_line("R3", "fresh frame remainder", rem, 16'h31C3);

    // R10 and R2: random packets with idle gaps
    for (int n = 0; n < 400; n++) begin
      logic [3:0] ch;
      int         len;
      ch  = 4'($urandom % 16);
      len = 1 + $urandom % 6;
      q.delete();
      for (int b = 0; b < len; b++) q.push_back(8'($urandom));
      send_pkt(ch, ($urandom % 4) == 0, ($urandom % 4) == 0, ($urandom % 2) == 0,
               q, 25, "R10", rem);
      if (($urandom % 3) == 0) idle(1 + $urandom % 3);
    end

    idle(10);
    n_cmp++; if (oq.size() != 0) fail_line("R2", "output bytes left", oq.size(), 0);
    n_cmp++; if (cq.size() != 0) fail_line("R7", "checks left", cq.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule